// File: doc/BRIEF.md
# Remote Framebuffer Bus Controller

This block sits behind a 32-bit register port and drives one or two external display panels over a shared 16-bit parallel bus. Each panel has its own select line, and a single A0 line tells the panel whether the current word is a command (A0 low) or a parameter/pixel word (A0 high). Software writes command, parameter and pixel registers. Each such write becomes a write strobe on the bus, sent to whichever panels the control register currently selects. Writes to two trigger registers start bus reads, and the returned word is kept in a receive buffer.

A 32-bit pixel word is sent as two consecutive bus cycles, low half-word first. Because of this, the register port is not ready for one cycle after every pixel write. A down-counting pixel counter tracks a transfer. A transfer is started by a control write, and the busy flag drops when the counter reaches zero. The per-panel timing, format and sync-width registers are only stored with their masks and read back. Offsets: 0x10 system config, 0x40 control, 0x44 pixel count, 0x48 line skip, 0x4C command, 0x50 parameter, 0x54 pixel data, 0x58 read trigger / receive buffer, 0x5C status trigger, 0x60–0x74 panel 0 bank, 0x78–0x8C panel 1 bank, 0x90 and 0x94 sync widths.

Top module: `rfb_bus_ctrl`

## Requirements
- R1: After reset, acc_ready is 1, reg_err and xfer_busy are 0, no bus strobe is active, and control and pixel count read back as 0.
- R2: Each panel bank holds six registers, in this order: config (mask 0x003F1FFF), on/off time (0x3FFFFFFF), cycle time (0x0FFFFFFF) and three data-cycle registers (0x0F1F0F1F). The line-skip register keeps 11 bits, and both sync-width registers keep 16 bits. Every one of these reads back as written AND its mask.
- R3: Control keeps bits [3:0]. System config keeps only bits 0, 3 and 4 (mask 0x19) as the idle field.
- R4: A command write (0x4C) drives bus_we for that one cycle, with bus_a0=0 and bus_dout = write data [15:0]. bus_cs[0] follows control bit 2 and bus_cs[1] follows control bit 3. With neither bit set, no strobe occurs.
- R5: A parameter write (0x50) behaves as R4, except that bus_a0=1.
- R6: A pixel write (0x54) strobes the low half-word with A0=1 in the access cycle, then the high half-word in the next cycle, to the same selects. During that second cycle acc_ready is 0, and any access presented is ignored.
- R7: A write to 0x58 (A0=1) or 0x5C (A0=0) raises bus_re for one cycle and loads bus_din into the receive buffer, which reads back at 0x58. Panel 0 is used when control bit 2 is set; otherwise panel 1 is used. Only one select is driven.
- R8: Pixel, read-trigger and status-trigger writes each decrement the pixel count (0x44), wrapping below zero. When the new count is zero, xfer_busy clears.
- R9: A control write with bit 4 set raises xfer_busy, unless the AND of the two bank config registers has bit 2 or bit 3 set.
- R10: A system-config write with bit 1 set clears control, pixel count, receive buffer, busy and all bank, line and sync registers, and loads the idle field from the same write.
- R11: Any read or write at an offset not listed above sets reg_err, which stays set until hardware reset. Such an access changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| acc_ready | output | 1 | Low while the pixel high half-word occupies the bus |
| reg_err | output | 1 | Sticky undefined-offset flag |
| xfer_busy | output | 1 | Transfer in progress |
| bus_cs | output | 2 | Per-panel select, one bit per panel |
| bus_a0 | output | 1 | 0 = command/status, 1 = parameter/pixel |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |

## Verification
The two events that share a cycle are a pixel write's second bus cycle and a new register access. The bench provokes this by holding reg_wr asserted straight after a pixel write and changing it to a control write. It then judges the outcome in two ways: the bus must show the high half-word with A0 high, and control must read back unchanged afterwards. A second overlap is the last pixel decrement clearing busy in the same cycle as the pixel strobe. That case is judged from xfer_busy and from the pixel count reading zero.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
   localparam int ADDR_W    = 8;
   localparam int NUM_CS    = 2;
   localparam int BANK_REGS = 6;

   localparam logic [ADDR_W-1:0] OFF_SYSCFG = 8'h10;
   localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h40;
   localparam logic [ADDR_W-1:0] OFF_PIXCNT = 8'h44;
   localparam logic [ADDR_W-1:0] OFF_LINE   = 8'h48;
   localparam logic [ADDR_W-1:0] OFF_CMD    = 8'h4C;
   localparam logic [ADDR_W-1:0] OFF_PARAM  = 8'h50;
   localparam logic [ADDR_W-1:0] OFF_DATA   = 8'h54;
   localparam logic [ADDR_W-1:0] OFF_RDDAT  = 8'h58;
   localparam logic [ADDR_W-1:0] OFF_RDSTAT = 8'h5C;
   localparam logic [ADDR_W-1:0] OFF_BANKLO = 8'h60;
   localparam logic [ADDR_W-1:0] OFF_BANKHI = 8'h8C;
   localparam logic [ADDR_W-1:0] OFF_VSYNC  = 8'h90;
   localparam logic [ADDR_W-1:0] OFF_HSYNC  = 8'h94;

   typedef enum logic [3:0] {
      K_BAD, K_SYSCFG, K_CTRL, K_PIXCNT, K_LINE, K_CMD, K_PARAM,
      K_DATA, K_RDDAT, K_RDSTAT, K_BANK, K_VSYNC, K_HSYNC
   } acc_kind_e;

   // mask applied to bank register by position within a panel bank
   function automatic logic [31:0] bank_mask(input int slot);
      case (slot)
         0:       return 32'h003F_1FFF;
         1:       return 32'h3FFF_FFFF;
         2:       return 32'h0FFF_FFFF;
         default: return 32'h0F1F_0F1F;
      endcase
   endfunction
endpackage

// File: rtl/rfb_decode.sv
module rfb_decode
   import rfb_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [3:0]        bank_idx
);
   always_comb begin
      kind     = K_BAD;
      bank_idx = '0;
      case (addr)
         OFF_SYSCFG: kind = K_SYSCFG;
         OFF_CTRL:   kind = K_CTRL;
         OFF_PIXCNT: kind = K_PIXCNT;
         OFF_LINE:   kind = K_LINE;
         OFF_CMD:    kind = K_CMD;
         OFF_PARAM:  kind = K_PARAM;
         OFF_DATA:   kind = K_DATA;
         OFF_RDDAT:  kind = K_RDDAT;
         OFF_RDSTAT: kind = K_RDSTAT;
         OFF_VSYNC:  kind = K_VSYNC;
         OFF_HSYNC:  kind = K_HSYNC;
         default: begin
            if (addr >= OFF_BANKLO && addr <= OFF_BANKHI && addr[1:0] == 2'b00) begin
               kind     = K_BANK;
               bank_idx = 4'((addr - OFF_BANKLO) >> 2);
            end
         end
      endcase
   end
endmodule

// File: rtl/rfb_cfg_regs.sv
module rfb_cfg_regs
   import rfb_pkg::*;
#(
   parameter int LINE_W = 11,
   parameter int SYNC_W = 16
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        wr_en,
   input  acc_kind_e   kind,
   input  logic [3:0]  bank_idx,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        start_block
);
   localparam int NREG = NUM_CS * BANK_REGS;

   logic [NREG-1:0][31:0] mask_w;
   logic [NREG-1:0][31:0] bank_q;
   logic [LINE_W-1:0]     line_q;
   logic [SYNC_W-1:0]     vs_q, hs_q;

   for (genvar g = 0; g < NREG; g++) begin : g_mask
      assign mask_w[g] = bank_mask(g % BANK_REGS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         line_q <= '0;
         vs_q   <= '0;
         hs_q   <= '0;
      end else if (soft_rst) begin
         bank_q <= '0;
         line_q <= '0;
         vs_q   <= '0;
         hs_q   <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NREG; i++)
            if (kind == K_BANK && bank_idx == 4'(i))
               bank_q[i] <= wdata & mask_w[i];
         if (kind == K_LINE)  line_q <= wdata[LINE_W-1:0];
         if (kind == K_VSYNC) vs_q   <= wdata[SYNC_W-1:0];
         if (kind == K_HSYNC) hs_q   <= wdata[SYNC_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (kind)
         K_BANK:  if (int'(bank_idx) < NREG) rdata = bank_q[bank_idx];
         K_LINE:  rdata = 32'(line_q);
         K_VSYNC: rdata = 32'(vs_q);
         K_HSYNC: rdata = 32'(hs_q);
         default: rdata = '0;
      endcase
   end

   // first config register of each bank gates the transfer start
   assign start_block = |(bank_q[0] & bank_q[BANK_REGS] & 32'h0000_000C);
endmodule

// File: rtl/rfb_bus_engine.sv
module rfb_bus_engine
   import rfb_pkg::*;
#(
   parameter int BUS_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               go,
   input  acc_kind_e          kind,
   input  logic [NUM_CS-1:0]  chip_en,
   input  logic [2*BUS_W-1:0] wdata,
   input  logic [BUS_W-1:0]   bus_din,
   output logic [NUM_CS-1:0]  bus_cs,
   output logic               bus_a0,
   output logic               bus_we,
   output logic               bus_re,
   output logic [BUS_W-1:0]   bus_dout,
   output logic [BUS_W-1:0]   rx_q,
   output logic               hi_pend
);
   logic [BUS_W-1:0]  hi_word;
   logic [NUM_CS-1:0] hi_cs;
   logic              any_cs;

   assign any_cs = |chip_en;

   always_comb begin
      bus_cs   = '0;
      bus_a0   = 1'b0;
      bus_we   = 1'b0;
      bus_re   = 1'b0;
      bus_dout = '0;
      if (hi_pend) begin
         bus_we   = 1'b1;
         bus_a0   = 1'b1;
         bus_cs   = hi_cs;
         bus_dout = hi_word;
      end else if (go && any_cs) begin
         case (kind)
            K_CMD, K_PARAM, K_DATA: begin
               bus_we   = 1'b1;
               bus_a0   = (kind != K_CMD);
               bus_cs   = chip_en;
               bus_dout = wdata[BUS_W-1:0];
            end
            K_RDDAT, K_RDSTAT: begin
               bus_re = 1'b1;
               bus_a0 = (kind == K_RDDAT);
               bus_cs = chip_en[0] ? NUM_CS'(1) : NUM_CS'(2);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_pend <= 1'b0;
         hi_word <= '0;
         hi_cs   <= '0;
         rx_q    <= '0;
      end else begin
         hi_pend <= go && any_cs && kind == K_DATA && !hi_pend;
         if (go && kind == K_DATA) begin
            hi_word <= wdata[2*BUS_W-1:BUS_W];
            hi_cs   <= chip_en;
         end
         if (soft_rst)    rx_q <= '0;
         else if (bus_re) rx_q <= bus_din;
      end
   end
endmodule

// File: rtl/rfb_bus_ctrl.sv
module rfb_bus_ctrl
   import rfb_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int PIX_W  = 32,
   parameter int LINE_W = 11,
   parameter int SYNC_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              acc_ready,
   output logic              reg_err,
   output logic              xfer_busy,
   output logic [1:0]        bus_cs,
   output logic              bus_a0,
   output logic              bus_we,
   output logic              bus_re,
   output logic [BUS_W-1:0]  bus_dout,
   input  logic [BUS_W-1:0]  bus_din
);
   localparam int REG_W = 32;

   if (2 * BUS_W != REG_W) begin : g_bad_bus
      $error("BUS_W must be half the register width");
   end
   if (PIX_W < 1 || PIX_W > REG_W) begin : g_bad_pix
      $error("PIX_W out of range");
   end
   if (LINE_W > REG_W || SYNC_W > REG_W) begin : g_bad_field
      $error("field width exceeds register width");
   end

   acc_kind_e         kind;
   logic [3:0]        bank_idx;
   logic              wr_ok, rd_ok, soft_rst, start_block, hi_pend;
   logic [REG_W-1:0]  cfg_rdata;
   logic [BUS_W-1:0]  rx_q;
   logic [3:0]        ctrl_q;
   logic [4:0]        idle_q;
   logic [PIX_W-1:0]  pix_q;
   logic              busy_q, err_q;

   rfb_decode u_dec (.addr(reg_addr), .kind(kind), .bank_idx(bank_idx));

   assign acc_ready = !hi_pend;
   assign wr_ok     = reg_wr && acc_ready;
   assign rd_ok     = reg_rd && acc_ready && !reg_wr;
   assign soft_rst  = wr_ok && kind == K_SYSCFG && reg_wdata[1];

   rfb_cfg_regs #(.LINE_W(LINE_W), .SYNC_W(SYNC_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_ok),
      .kind(kind), .bank_idx(bank_idx), .wdata(reg_wdata),
      .rdata(cfg_rdata), .start_block(start_block)
   );

   rfb_bus_engine #(.BUS_W(BUS_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .go(wr_ok),
      .kind(kind), .chip_en(ctrl_q[3:2]), .wdata(reg_wdata),
      .bus_din(bus_din), .bus_cs(bus_cs), .bus_a0(bus_a0),
      .bus_we(bus_we), .bus_re(bus_re), .bus_dout(bus_dout),
      .rx_q(rx_q), .hi_pend(hi_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         idle_q <= '0;
         pix_q  <= '0;
         busy_q <= 1'b0;
      end else if (soft_rst) begin
         ctrl_q <= '0;
         pix_q  <= '0;
         busy_q <= 1'b0;
         idle_q <= reg_wdata[4:0] & 5'h19;
      end else if (wr_ok) begin
         case (kind)
            K_SYSCFG: idle_q <= reg_wdata[4:0] & 5'h19;
            K_CTRL: begin
               ctrl_q <= reg_wdata[3:0];
               if (reg_wdata[4] && !start_block) busy_q <= 1'b1;
            end
            K_PIXCNT: pix_q <= reg_wdata[PIX_W-1:0];
            K_DATA, K_RDDAT, K_RDSTAT: begin
               pix_q <= pix_q - PIX_W'(1);
               if (pix_q == PIX_W'(1)) busy_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         err_q <= 1'b0;
      else if ((wr_ok || rd_ok || (reg_rd && acc_ready)) && kind == K_BAD) err_q <= 1'b1;
   end

   always_comb begin
      case (kind)
         K_SYSCFG: reg_rdata = REG_W'(idle_q);
         K_CTRL:   reg_rdata = REG_W'(ctrl_q);
         K_PIXCNT: reg_rdata = REG_W'(pix_q);
         K_RDDAT:  reg_rdata = REG_W'(rx_q);
         default:  reg_rdata = cfg_rdata;
      endcase
   end

   assign reg_err   = err_q;
   assign xfer_busy = busy_q;
endmodule

// File: rtl/rfb_bus_ctrl_chk.sv
module rfb_bus_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [7:0] reg_addr,
   input logic       acc_ready,
   input logic       reg_err,
   input logic [1:0] bus_cs,
   input logic       bus_a0,
   input logic       bus_we,
   input logic       bus_re
);
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   assert_cs_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we || bus_re) |-> bus_cs != 2'b00);

   assert_read_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |-> $countones(bus_cs) == 1);

   assert_cmd_a0_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && acc_ready && reg_addr == 8'h4C && bus_we) |-> !bus_a0);

   assert_high_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_ready |-> (bus_we && bus_a0 && !bus_re));

   assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_ready |=> acc_ready);

   assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_ready |-> ($past(reg_wr) && $past(reg_addr) == 8'h54));

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |=> reg_err);
endmodule

bind rfb_bus_ctrl rfb_bus_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .acc_ready(acc_ready), .reg_err(reg_err), .bus_cs(bus_cs),
   .bus_a0(bus_a0), .bus_we(bus_we), .bus_re(bus_re)
);

// File: tb/rfb_bus_ctrl_tb.sv
module rfb_bus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_ready, reg_err, xfer_busy, bus_a0, bus_we, bus_re;
   logic [1:0]  bus_cs;
   logic [15:0] bus_dout;
   logic [15:0] bus_din = '0;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   logic        c_we, c_re, c_a0, h_we, h_a0, h_rdy;
   logic [1:0]  c_cs, h_cs;
   logic [15:0] c_dout, h_dout;
   logic [31:0] rd_val;

   always #2 clk = ~clk;

   rfb_bus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_ready(acc_ready), .reg_err(reg_err), .xfer_busy(xfer_busy),
      .bus_cs(bus_cs), .bus_a0(bus_a0), .bus_we(bus_we), .bus_re(bus_re),
      .bus_dout(bus_dout), .bus_din(bus_din)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      #1;
      c_we = bus_we; c_re = bus_re; c_a0 = bus_a0; c_cs = bus_cs; c_dout = bus_dout;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      #0.5;
      h_we = bus_we; h_a0 = bus_a0; h_cs = bus_cs; h_dout = bus_dout; h_rdy = acc_ready;
      if (!h_rdy) @(posedge clk);
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      rd_val = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 acc_ready", 32'(acc_ready), 1);
      chk("R1 err", 32'(reg_err), 0);
      chk("R1 busy", 32'(xfer_busy), 0);
      chk("R1 strobes", {30'b0, bus_we, bus_re}, 0);
      rd(8'h40); chk("R1 control", rd_val, 0);
      rd(8'h44); chk("R1 pixcnt", rd_val, 0);
   endtask

   task automatic t_masks;
      wr(8'h60, '1); wr(8'h64, '1); wr(8'h68, '1); wr(8'h6C, '1);
      wr(8'h8C, '1); wr(8'h78, '1); wr(8'h48, '1); wr(8'h90, '1); wr(8'h94, 32'h1234_5678);
      rd(8'h60); chk("R2 cfg0", rd_val, 32'h003F_1FFF);
      rd(8'h64); chk("R2 onoff0", rd_val, 32'h3FFF_FFFF);
      rd(8'h68); chk("R2 cycle0", rd_val, 32'h0FFF_FFFF);
      rd(8'h6C); chk("R2 dcyc0", rd_val, 32'h0F1F_0F1F);
      rd(8'h8C); chk("R2 dcyc1_last", rd_val, 32'h0F1F_0F1F);
      rd(8'h78); chk("R2 cfg1", rd_val, 32'h003F_1FFF);
      rd(8'h48); chk("R2 line", rd_val, 32'h0000_07FF);
      rd(8'h90); chk("R2 vsync", rd_val, 32'h0000_FFFF);
      rd(8'h94); chk("R2 hsync", rd_val, 32'h0000_5678);
   endtask

   task automatic t_ctrl_sys;
      // both configs carry bits 2/3 here, so bit 4 must not start (R9)
      wr(8'h40, 32'hFF); rd(8'h40); chk("R3 control low bits", rd_val, 32'hF);
      chk("R9 start suppressed", 32'(xfer_busy), 0);
      wr(8'h10, 32'h1D); rd(8'h10); chk("R3 idle field", rd_val, 32'h19);
   endtask

   task automatic t_soft_reset_initial;
      wr(8'h10, 32'h02);
      rd(8'h60); chk("R10 bank cleared", rd_val, 0);
      rd(8'h48); chk("R10 line cleared", rd_val, 0);
      rd(8'h40); chk("R10 control cleared", rd_val, 0);
      rd(8'h10); chk("R10 idle from write", rd_val, 0);
   endtask

   task automatic t_cmd_param;
      wr(8'h40, 32'h4);
      wr(8'h4C, 32'hABCD_1234);
      chk("R4 cmd we", 32'(c_we), 1); chk("R4 cmd a0", 32'(c_a0), 0);
      chk("R4 cmd cs", 32'(c_cs), 1); chk("R4 cmd dout", 32'(c_dout), 32'h1234);
      chk("R4 single strobe", 32'(h_we), 0);
      wr(8'h40, 32'hC);
      wr(8'h4C, 32'h0000_BEEF);
      chk("R4 cmd both cs", 32'(c_cs), 3);
      wr(8'h40, 32'h0);
      wr(8'h4C, 32'h0000_1111);
      chk("R4 no chip no strobe", 32'(c_we), 0);
      wr(8'h40, 32'h8);
      wr(8'h50, 32'h5555_7777);
      chk("R5 param a0", 32'(c_a0), 1); chk("R5 param cs", 32'(c_cs), 2);
      chk("R5 param dout", 32'(c_dout), 32'h7777); chk("R5 param we", 32'(c_we), 1);
   endtask

   task automatic t_data;
      wr(8'h44, 32'd2);
      wr(8'h40, 32'h1C);
      chk("R9 start busy", 32'(xfer_busy), 1);
      rd(8'h40); chk("R3 control keeps 4 bits", rd_val, 32'hC);
      wr(8'h54, 32'h89AB_4567);
      chk("R6 low we", 32'(c_we), 1); chk("R6 low a0", 32'(c_a0), 1);
      chk("R6 low dout", 32'(c_dout), 32'h4567); chk("R6 low cs", 32'(c_cs), 3);
      chk("R6 high we", 32'(h_we), 1); chk("R6 high a0", 32'(h_a0), 1);
      chk("R6 high dout", 32'(h_dout), 32'h89AB); chk("R6 high cs", 32'(h_cs), 3);
      chk("R6 not ready", 32'(h_rdy), 0);
      rd(8'h44); chk("R8 pix decrement", rd_val, 1);
      chk("R8 busy held", 32'(xfer_busy), 1);
   endtask

   task automatic t_collide;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h54; reg_wdata = 32'h2222_1111;
      @(posedge clk); #1;
      reg_addr = 8'h40; reg_wdata = 32'h0;
      #0.5;
      chk("R6 collide high half", 32'(bus_dout), 32'h2222);
      chk("R6 collide a0", 32'(bus_a0), 1);
      @(posedge clk); #1;
      reg_wr = 1'b0;
      rd(8'h40); chk("R6 ignored control write", rd_val, 32'hC);
      rd(8'h44); chk("R8 pix reaches zero", rd_val, 0);
      chk("R8 busy cleared at zero", 32'(xfer_busy), 0);
      wr(8'h54, 32'h0);
      rd(8'h44); chk("R8 pix wraps", rd_val, 32'hFFFF_FFFF);
      chk("R8 no busy after wrap", 32'(xfer_busy), 0);
   endtask

   task automatic t_reads;
      wr(8'h44, 32'd5);
      wr(8'h40, 32'hC);
      bus_din = 16'h5A5A;
      wr(8'h58, 32'h0);
      chk("R7 read re", 32'(c_re), 1); chk("R7 read a0", 32'(c_a0), 1);
      chk("R7 chip0 priority", 32'(c_cs), 1); chk("R7 read no we", 32'(c_we), 0);
      rd(8'h58); chk("R7 rxbuf", rd_val, 32'h5A5A);
      wr(8'h40, 32'h8);
      bus_din = 16'hC3C3;
      wr(8'h5C, 32'h0);
      chk("R7 status a0", 32'(c_a0), 0); chk("R7 status cs", 32'(c_cs), 2);
      rd(8'h58); chk("R7 status rxbuf", rd_val, 32'hC3C3);
      rd(8'h44); chk("R8 read accesses count", rd_val, 3);
   endtask

   task automatic t_start_gate;
      wr(8'h60, 32'h4); wr(8'h78, 32'h4);
      wr(8'h40, 32'h10);
      chk("R9 shared bit blocks start", 32'(xfer_busy), 0);
      wr(8'h78, 32'h8);
      wr(8'h40, 32'h10);
      chk("R9 start allowed", 32'(xfer_busy), 1);
      wr(8'h10, 32'h1B);
      chk("R10 busy cleared", 32'(xfer_busy), 0);
      rd(8'h44); chk("R10 pix cleared", rd_val, 0);
      rd(8'h58); chk("R10 rxbuf cleared", rd_val, 0);
      rd(8'h60); chk("R10 cfg cleared", rd_val, 0);
      rd(8'h10); chk("R10 idle loaded", rd_val, 32'h19);
   endtask

   task automatic t_error;
      chk("R11 err clear before", 32'(reg_err), 0);
      wr(8'h40, 32'h4);
      wr(8'h00, 32'hF);
      chk("R11 err set", 32'(reg_err), 1);
      rd(8'h40); chk("R11 no side effect", rd_val, 32'h4);
      rd(8'h42);
      wr(8'h98, 32'hF);
      chk("R11 err sticky", 32'(reg_err), 1);
      rd(8'h40); chk("R11 control intact", rd_val, 32'h4);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_masks();
      t_ctrl_sys();
      t_soft_reset_initial();
      t_cmd_param();
      t_data();
      t_collide();
      t_reads();
      t_start_gate();
      t_error();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule